// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block is a small controller-side engine that brings a two-wire serial bus back to a known state. A transfer may be cut short by a reset, a brown-out or a firmware fault. When that happens, an attached target can be left holding SDA low in the middle of a byte. A one-cycle request starts the engine, which then drives a fixed waveform on the open-drain SCL and SDA lines:

1. A start condition.
2. Nine dummy clock pulses with SDA released.
3. A second start condition.
4. A stop condition straight after it.

The outputs are drive enables: 1 pulls the line low, and 0 releases it to its pull-up. The waveform is built from segments, and each segment lasts `div` system clocks, so every SCL phase lasts two segments. SDA changes that are neither a start nor a stop fall at the boundary in the middle of an SCL-low phase. After the final release the block raises a one-cycle `done` pulse, and the bus can then carry normal traffic.

Top module: `busclr_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, `scl_oe` and `sda_oe` are 0 (both lines released) and `done` is 0.
- R2: A sequence starts on a clock edge where `req` is 1 and no sequence is running. The waveform is 52 segments of `div` clocks each, numbered from 0. SCL is released in segments 0–1, and SDA is pulled low in segment 2 while SCL is still released. This is the first start condition.
- R3: Between the two start conditions SCL makes exactly nine release pulses. Each pulse is two segments released followed by two segments pulled low, starting at segment 6. SDA is released from segment 5 through segment 43.
- R4: The second start pulls SDA low at segment 44 while SCL is released. SCL is then pulled low for segments 46–47 with SDA kept low. SCL is released again at segment 48, and SDA is released at segment 50 while SCL stays released. This is the stop condition.
- R5: SCL and SDA never change in the same system clock. SDA is pulled low only while SCL is released. SDA is released while SCL is released only at the stop.
- R6: Each segment lasts exactly `div` system clocks. A `div` of 0 is treated as 1.
- R7: `done` is 1 for exactly one clock. That clock comes directly after the last segment, when both lines are already released, which is 52×`div` clocks after the accepting edge.
- R8: While a sequence runs, `req` is ignored and changes on `div` have no effect. The divider value is captured at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start request, sampled while idle |
| div | input | DIV_W | Segment length in system clocks (0 acts as 1) |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| done | output | 1 | One-clock completion pulse |

## Verification
The hardest case to reach is a request, together with a new divider value, arriving in the middle of a running sequence. If the block wrongly accepted either one, the waveform would restart or stretch. The bench raises `req` and rewrites `div` partway through chosen runs, at random positions, and then checks the full 52-segment waveform against the divider captured at the start. It also counts the start, stop and clock edges seen on the lines, so a wrong ordering shows up even when the segment timing is correct.

// File: rtl/busclr_seq.sv
module busclr_seq #(
  parameter int DIV_W  = 8,
  parameter int CLOCKS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [DIV_W-1:0] div,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             done
);
  localparam int CLK_END  = 6 + 4 * CLOCKS;
  localparam int SEG_LAST = CLK_END + 9;
  localparam int SEG_W    = $clog2(SEG_LAST + 1);

  logic             busy;
  logic [SEG_W-1:0] seg;
  logic [DIV_W-1:0] cnt, div_q;
  logic             scl_low, sda_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      seg   <= '0;
      cnt   <= '0;
      div_q <= DIV_W'(1);
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy  <= 1'b1;
          seg   <= '0;
          cnt   <= '0;
          div_q <= (div == '0) ? DIV_W'(1) : div;
        end
      end else if (cnt == div_q - DIV_W'(1)) begin
        cnt <= '0;
        if (seg == SEG_W'(SEG_LAST)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          seg <= seg + SEG_W'(1);
        end
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  always_comb begin
    int s;
    s = int'(seg);
    scl_low = (s >= 4 && s < 6)
           || (s >= 6 && s < CLK_END && ((s - 6) % 4) >= 2)
           || (s >= CLK_END + 4 && s < CLK_END + 6);
    sda_low = (s >= 2 && s < 5)
           || (s >= CLK_END + 2 && s < CLK_END + 8);
  end

  assign scl_oe = busy & scl_low;
  assign sda_oe = busy & sda_low;
endmodule

// File: rtl/busclr_seq_chk.sv
module busclr_seq_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             busy,
  input logic [DIV_W-1:0] div_q,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             done
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  assert_no_joint_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(scl_oe) && !$stable(sda_oe)));

  assert_sda_pull_scl_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_oe);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scl_oe && !sda_oe && !busy));

  assert_div_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div_q));
endmodule

bind busclr_seq busclr_seq_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .div_q(div_q),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done)
);

// File: tb/busclr_seq_tb.sv
module busclr_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [7:0] div = 8'd1;
  logic       scl_oe, sda_oe, done;
  int         errors = 0;
  int         checks = 0;
  int         cycles = 0;

  busclr_seq #(.DIV_W(8), .CLOCKS(9)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .div(div),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected SCL pull per segment: start margin, nine pulses, second start, stop
  function automatic bit exp_scl(int s);
    if (s == 4 || s == 5 || s == 46 || s == 47) return 1'b1;
    if (s >= 6 && s <= 41) return ((s - 6) / 2) % 2 == 1;
    return 1'b0;
  endfunction

  function automatic bit exp_sda(int s);
    return (s >= 2 && s <= 4) || (s >= 44 && s <= 49);
  endfunction

  task automatic run(int d, int poke_at, string name);
    int eff, bad, starts, stops, rises, done_at, done_cnt;
    bit pscl, psda;
    eff = (d == 0) ? 1 : d;
    bad = 0; starts = 0; stops = 0; rises = 0; done_at = -1; done_cnt = 0;
    pscl = 0; psda = 0;
    div = 8'(d);
    req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i <= 52 * eff + 3; i++) begin
      if (i > 0) @(negedge clk);
      if (i < 52 * eff) begin
        if (scl_oe !== exp_scl(i / eff) || sda_oe !== exp_sda(i / eff)) begin
          if (bad == 0)
            $display("FAIL R2/R3/R4/R6 %s sample %0d: scl=%0b sda=%0b expected scl=%0b sda=%0b",
                     name, i, scl_oe, sda_oe, exp_scl(i / eff), exp_sda(i / eff));
          bad++;
        end
      end else if (scl_oe !== 1'b0 || sda_oe !== 1'b0) begin
        bad++;
        $display("FAIL R1 %s sample %0d: lines not released", name, i);
      end
      if (!pscl && !psda && sda_oe && !scl_oe) starts++;
      if (!pscl && psda && !sda_oe && !scl_oe) stops++;
      if (pscl && !scl_oe) rises++;
      if (done) begin done_cnt++; if (done_at < 0) done_at = i; end
      pscl = scl_oe; psda = sda_oe;
      if (poke_at >= 0 && i == poke_at) begin
        req = 1'b1; div = 8'($urandom_range(1, 9));
      end else begin
        req = 1'b0;
      end
    end
    req = 1'b0;
    checks++;
    if (bad != 0) errors++;
    check({"R3 start count ", name}, starts, 2);
    check({"R4 stop count ", name}, stops, 1);
    check({"R3 scl releases ", name}, rises, 11);
    check({"R7 done cycle ", name}, done_at, 52 * eff);
    check({"R7 done width ", name}, done_cnt, 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    #1;
    check("R1 reset scl", int'(scl_oe), 0);
    check("R1 reset sda", int'(sda_oe), 0);
    check("R1 reset done", int'(done), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle scl", int'(scl_oe), 0);
    run(1, -1, "R6 div1");
    run(0, -1, "R6 div0");
    run(3, 40, "R8 poke");
    run(2, 103, "R8 lastseg poke");
    for (int k = 0; k < 6; k++) begin
      int d, p;
      d = $urandom_range(1, 6);
      p = $urandom_range(0, 52 * d - 1);
      repeat ($urandom_range(0, 4)) @(negedge clk);
      run(d, p, "R5 random");
    end
    repeat (5) @(negedge clk);
    check("R8 no late restart", int'(scl_oe | sda_oe), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule